// File: doc/BRIEF.md
# Transmitter On/Off Control Logic

This block is the synchronous start/stop controller for a broadcast transmitter. Turn-on and turn-off requests come from the front panel or from one or more remote control sources. A local-mode level decides whether the remote sources are heard at all. The block keeps the on/off decision in a one-bit memory. It enables the line contactor only while that memory is set and an external failsafe interlock loop is closed. It also drives indicators for the OFF state, the ON state, POWER ON and LOCAL mode.

A second memory captures a reject-load fault reported by a comparator. While that fault is held, the block raises an alarm and asks the drive stage to reduce drive. The fault does not switch the transmitter off. A turn-on request clears the fault. If the comparator still reports the fault, it is captured again one cycle later.

Each memory is a small state machine. The power machine has two states, PWR_OFF and PWR_ON. Its transitions are T_TURN_ON (PWR_OFF to PWR_ON on an effective ON request with no effective OFF request) and T_TURN_OFF (PWR_ON to PWR_OFF on an effective OFF request). The fault machine has two states, FLT_CLEAR and FLT_HELD. Its transitions are T_CAPTURE (FLT_CLEAR to FLT_HELD when the comparator is high and no effective ON request is present) and T_RELEASE (FLT_HELD to FLT_CLEAR on an effective ON request). Any other input holds the current state.

Top module: `txctl_top`

## Requirements
- R1: While `local_mode` is 1, the `remote_on` and `remote_off` inputs have no effect on any output.
- R2: While `local_mode` is 0, a remote ON or OFF pulse has the same effect as the matching front-panel pulse.
- R3: An effective ON request sets the power memory. An effective OFF request clears it. With neither request the memory holds. The new state shows on the outputs after the next rising clock edge.
- R4: When effective ON and effective OFF requests occur in the same cycle, the power memory ends up cleared.
- R5: `contactor_en` and `led_power_on` are 1 exactly when the power memory is set and `interlock_ok` is 1. This is a combinational function of the current `interlock_ok`.
- R6: `led_on` is 1 when the power memory is set. `led_off` is 1 when it is clear. `led_local` follows `local_mode`.
- R7: With the comparator input `reject_hot` at 1 and no effective ON request, the fault memory is set after the next clock edge. While it is set, `fault_alarm` and `drive_reduce` are both 1.
- R8: An effective ON request clears the fault memory after the next edge. This holds even when OFF is also requested, and even when `reject_hot` is 1. If `reject_hot` is still 1 in the following cycle, the memory is set again one edge later.
- R9: The state of the fault memory never changes the power memory or the contactor enable.
- R10: A low `rst_n` at a clock edge clears the fault memory. With `RETAIN_ON_RESET` = 0 it also clears the power memory. With `RETAIN_ON_RESET` = 1 the power memory holds its state through reset, and commands are ignored during reset.
- R11: Each of the `NUM_REMOTE` remote sources is gated by `local_mode` on its own. The gated sources are then OR-combined, so a pulse on any single source counts as a remote request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| panel_on | input | 1 | Front-panel turn-on pulse |
| panel_off | input | 1 | Front-panel turn-off pulse |
| remote_on | input | NUM_REMOTE | Remote turn-on pulses, one per source |
| remote_off | input | NUM_REMOTE | Remote turn-off pulses, one per source |
| local_mode | input | 1 | 1 = local control, remote sources ignored |
| interlock_ok | input | 1 | 1 = failsafe interlock loop closed |
| reject_hot | input | 1 | Reject-load comparator output, 1 = fault |
| contactor_en | output | 1 | Line-contactor enable |
| led_power_on | output | 1 | POWER ON indicator |
| led_off | output | 1 | OFF indicator |
| led_on | output | 1 | ON indicator |
| led_local | output | 1 | LOCAL mode indicator |
| fault_alarm | output | 1 | Reject-load fault alarm |
| drive_reduce | output | 1 | Request to reduce drive |

## Verification
The bench builds two copies of the block with `NUM_REMOTE` = 2, one with `RETAIN_ON_RESET` = 0 and one with `RETAIN_ON_RESET` = 1. With two remote sources, gating and OR-combining of each source separately can be observed. With both reset variants, retention and clearing of the power memory can be compared side by side. From each of the four combinations of power and fault state, the bench applies every one of the 512 values of the nine request and level inputs. It then runs one further cycle with the commands removed, which exposes the OFF priority, the local suppression and the re-capture of a persistent fault.

// File: rtl/txctl_pkg.sv
package txctl_pkg;

    typedef enum logic {
        PWR_OFF = 1'b0,
        PWR_ON  = 1'b1
    } pwr_state_t;

    typedef enum logic {
        FLT_CLEAR = 1'b0,
        FLT_HELD  = 1'b1
    } flt_state_t;

endpackage

// File: rtl/txctl_cmd_merge.sv
module txctl_cmd_merge #(
    parameter int NUM_REMOTE = 1
) (
    input  logic                  panel_on,
    input  logic                  panel_off,
    input  logic [NUM_REMOTE-1:0] remote_on,
    input  logic [NUM_REMOTE-1:0] remote_off,
    input  logic                  local_mode,
    output logic                  on_req,
    output logic                  off_req
);
    logic [NUM_REMOTE-1:0] gated_on;
    logic [NUM_REMOTE-1:0] gated_off;

    // each remote source is shunted separately while in local mode
    for (genvar g = 0; g < NUM_REMOTE; g++) begin : g_gate
        assign gated_on[g]  = remote_on[g]  & ~local_mode;
        assign gated_off[g] = remote_off[g] & ~local_mode;
    end

    assign on_req  = panel_on  | (|gated_on);
    assign off_req = panel_off | (|gated_off);
endmodule

// File: rtl/txctl_power_fsm.sv
module txctl_power_fsm
    import txctl_pkg::*;
#(
    parameter bit RETAIN_ON_RESET = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       on_req,
    input  logic       off_req,
    output pwr_state_t state
);
    pwr_state_t state_q = PWR_OFF;
    pwr_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_OFF: if (on_req && !off_req) state_d = PWR_ON;   // T_TURN_ON
            PWR_ON:  if (off_req)            state_d = PWR_OFF;  // T_TURN_OFF
            default: state_d = PWR_OFF;
        endcase
    end

    if (RETAIN_ON_RESET) begin : g_retain
        always_ff @(posedge clk) begin
            if (rst_n) state_q <= state_d;
        end
    end else begin : g_clear
        always_ff @(posedge clk) begin
            if (!rst_n) state_q <= PWR_OFF;
            else        state_q <= state_d;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/txctl_fault_fsm.sv
module txctl_fault_fsm
    import txctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       on_req,
    input  logic       reject_hot,
    output flt_state_t state
);
    flt_state_t state_q;
    flt_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLT_CLEAR: if (reject_hot && !on_req) state_d = FLT_HELD;  // T_CAPTURE
            FLT_HELD:  if (on_req)                state_d = FLT_CLEAR; // T_RELEASE
            default:   state_d = FLT_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLT_CLEAR;
        else        state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/txctl_top.sv
module txctl_top
    import txctl_pkg::*;
#(
    parameter int NUM_REMOTE      = 1,
    parameter bit RETAIN_ON_RESET = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  panel_on,
    input  logic                  panel_off,
    input  logic [NUM_REMOTE-1:0] remote_on,
    input  logic [NUM_REMOTE-1:0] remote_off,
    input  logic                  local_mode,
    input  logic                  interlock_ok,
    input  logic                  reject_hot,
    output logic                  contactor_en,
    output logic                  led_power_on,
    output logic                  led_off,
    output logic                  led_on,
    output logic                  led_local,
    output logic                  fault_alarm,
    output logic                  drive_reduce
);
    logic       on_req;
    logic       off_req;
    pwr_state_t pwr_state;
    flt_state_t flt_state;

    txctl_cmd_merge #(.NUM_REMOTE(NUM_REMOTE)) u_merge (
        .panel_on   (panel_on),
        .panel_off  (panel_off),
        .remote_on  (remote_on),
        .remote_off (remote_off),
        .local_mode (local_mode),
        .on_req     (on_req),
        .off_req    (off_req)
    );

    txctl_power_fsm #(.RETAIN_ON_RESET(RETAIN_ON_RESET)) u_power (
        .clk     (clk),
        .rst_n   (rst_n),
        .on_req  (on_req),
        .off_req (off_req),
        .state   (pwr_state)
    );

    txctl_fault_fsm u_fault (
        .clk        (clk),
        .rst_n      (rst_n),
        .on_req     (on_req),
        .reject_hot (reject_hot),
        .state      (flt_state)
    );

    always_comb begin
        led_on       = 1'b0;
        led_off      = 1'b0;
        contactor_en = 1'b0;
        unique case (pwr_state)
            PWR_OFF: led_off = 1'b1;
            PWR_ON: begin
                led_on       = 1'b1;
                contactor_en = interlock_ok;
            end
            default: led_off = 1'b1;
        endcase
        led_power_on = contactor_en;
        led_local    = local_mode;
    end

    always_comb begin
        fault_alarm  = 1'b0;
        drive_reduce = 1'b0;
        unique case (flt_state)
            FLT_CLEAR: ;
            FLT_HELD: begin
                fault_alarm  = 1'b1;
                drive_reduce = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/txctl_checker.sv
module txctl_checker #(
    parameter int NUM_REMOTE = 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  panel_on,
    input logic                  panel_off,
    input logic [NUM_REMOTE-1:0] remote_on,
    input logic [NUM_REMOTE-1:0] remote_off,
    input logic                  local_mode,
    input logic                  interlock_ok,
    input logic                  reject_hot,
    input logic                  contactor_en,
    input logic                  led_power_on,
    input logic                  led_off,
    input logic                  led_on,
    input logic                  fault_alarm,
    input logic                  drive_reduce
);
    logic eff_on;
    logic eff_off;
    assign eff_on  = panel_on  || ((|remote_on)  && !local_mode);
    assign eff_off = panel_off || ((|remote_off) && !local_mode);

    assert_local_shunt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (local_mode && !panel_on && !panel_off) |=> $stable(led_on));

    assert_off_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eff_off |=> led_off);

    assert_contactor_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (contactor_en || led_power_on) |-> (interlock_ok && led_on));

    assert_led_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        led_on != led_off);

    assert_fault_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reject_hot && !eff_on) |=> (fault_alarm && drive_reduce));

    assert_fault_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eff_on |=> !fault_alarm);

    assert_fault_no_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (led_on && !eff_off) |=> led_on);

    assert_reset_clears_fault_R10: assert property (@(posedge clk)
        !rst_n |=> !fault_alarm);
endmodule

bind txctl_top txctl_checker #(.NUM_REMOTE(NUM_REMOTE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .panel_on     (panel_on),
    .panel_off    (panel_off),
    .remote_on    (remote_on),
    .remote_off   (remote_off),
    .local_mode   (local_mode),
    .interlock_ok (interlock_ok),
    .reject_hot   (reject_hot),
    .contactor_en (contactor_en),
    .led_power_on (led_power_on),
    .led_off      (led_off),
    .led_on       (led_on),
    .fault_alarm  (fault_alarm),
    .drive_reduce (drive_reduce)
);

// File: tb/txctl_top_tb.sv
module txctl_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic panel_on = 0, panel_off = 0, local_mode = 0, interlock_ok = 0, reject_hot = 0;
    logic [NR-1:0] remote_on = '0, remote_off = '0;

    logic c_en [2], c_pon [2], c_off [2], c_on [2], c_loc [2], c_flt [2], c_drv [2];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txctl_top #(.NUM_REMOTE(NR), .RETAIN_ON_RESET(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .panel_on(panel_on), .panel_off(panel_off),
        .remote_on(remote_on), .remote_off(remote_off), .local_mode(local_mode),
        .interlock_ok(interlock_ok), .reject_hot(reject_hot),
        .contactor_en(c_en[0]), .led_power_on(c_pon[0]), .led_off(c_off[0]),
        .led_on(c_on[0]), .led_local(c_loc[0]), .fault_alarm(c_flt[0]),
        .drive_reduce(c_drv[0])
    );

    txctl_top #(.NUM_REMOTE(NR), .RETAIN_ON_RESET(1'b1)) u_dut_ret (
        .clk(clk), .rst_n(rst_n), .panel_on(panel_on), .panel_off(panel_off),
        .remote_on(remote_on), .remote_off(remote_off), .local_mode(local_mode),
        .interlock_ok(interlock_ok), .reject_hot(reject_hot),
        .contactor_en(c_en[1]), .led_power_on(c_pon[1]), .led_off(c_off[1]),
        .led_on(c_on[1]), .led_local(c_loc[1]), .fault_alarm(c_flt[1]),
        .drive_reduce(c_drv[1])
    );

    task automatic check(string tag, int inst, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s inst=%0d t=%0t actual=%b expected=%b", tag, inst, $time, act, exp);
        end
    endtask

    // apply inputs on the falling edge, then look just after the rising edge
    task automatic step(logic pon, logic poff, logic [NR-1:0] ron, logic [NR-1:0] roff,
                        logic loc, logic ilk, logic rej);
        @(negedge clk);
        panel_on = pon; panel_off = poff; remote_on = ron; remote_off = roff;
        local_mode = loc; interlock_ok = ilk; reject_hot = rej;
        @(posedge clk);
        #1;
    endtask

    task automatic check_all(string ptag, string ftag, int inst, logic pwr, logic flt,
                             logic ilk, logic loc);
        check(ptag, inst, c_on[inst], pwr);
        check(ptag, inst, c_off[inst], !pwr);
        check("R5", inst, c_en[inst], pwr && ilk);
        check("R5", inst, c_pon[inst], pwr && ilk);
        check("R6", inst, c_loc[inst], loc);
        check(ftag, inst, c_flt[inst], flt);
        check(ftag, inst, c_drv[inst], flt);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // reset state
        repeat (3) @(posedge clk);
        #1;
        for (int i = 0; i < 2; i++) check_all("R10", "R10", i, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // exhaustive sweep over starting state and all input values
        for (int st = 0; st < 4; st++) begin
            for (int v = 0; v < 512; v++) begin
                logic pp, pf, p_on, p_off, loc, ilk, rej, eon, eoff, epwr, eflt;
                logic [NR-1:0] ron, roff;
                string ptag, ftag;
                pp = st[0]; pf = st[1];
                step(1, 0, '0, '0, 0, 1, 0);
                if (!pp) step(0, 1, '0, '0, 0, 1, 0);
                if (pf)  step(0, 0, '0, '0, 0, 1, 1);
                p_on = v[0]; p_off = v[1]; ron = v[3:2]; roff = v[5:4];
                loc = v[6]; ilk = v[7]; rej = v[8];
                eon  = p_on  || ((|ron)  && !loc);
                eoff = p_off || ((|roff) && !loc);
                epwr = eoff ? 1'b0 : (eon ? 1'b1 : pp);
                eflt = eon ? 1'b0 : (rej ? 1'b1 : pf);
                if (eon && eoff)                                ptag = "R4";
                else if (loc && ((|ron) || (|roff)))           ptag = "R1";
                else if (!loc && (ron == 2'b10 || roff == 2'b10)) ptag = "R11";
                else if (!loc && ((|ron) || (|roff)))          ptag = "R2";
                else if (pf || rej)                            ptag = "R9";
                else                                           ptag = "R3";
                ftag = eon ? "R8" : "R7";
                step(p_on, p_off, ron, roff, loc, ilk, rej);
                for (int i = 0; i < 2; i++) check_all(ptag, ftag, i, epwr, eflt, ilk, loc);
                // commands removed, levels held: a persistent fault is captured again
                step(0, 0, '0, '0, loc, ilk, rej);
                for (int i = 0; i < 2; i++)
                    check_all("R9", "R8", i, epwr, rej ? 1'b1 : eflt, ilk, loc);
            end
        end

        // reset with power on and fault held: retention differs by variant
        step(1, 0, '0, '0, 0, 1, 0);
        step(0, 0, '0, '0, 0, 1, 1);
        @(negedge clk); rst_n = 1'b0; reject_hot = 1'b0; panel_off = 1'b1;
        @(posedge clk); #1;
        check_all("R10", "R10", 0, 1'b0, 1'b0, 1'b1, 1'b0);
        check_all("R10", "R10", 1, 1'b1, 1'b0, 1'b1, 1'b0);
        @(negedge clk); rst_n = 1'b1; panel_off = 1'b0;
        @(posedge clk); #1;
        check_all("R10", "R10", 1, 1'b1, 1'b0, 1'b1, 1'b0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule